// File: doc/BRIEF.md
# DMA Channel Register Bank and Request Gate

This block holds the programming state of a set of DMA channels and decides, one request at a time, whether a device may start a transfer. Software reaches the registers over a simple 32-bit memory-mapped port that accepts word, halfword and byte writes. Each channel has three registers: a mode word, which carries the enable, the direction and three status flags; a remaining-count register; and a start-address register. One shared error-source register collects a sticky bit for every channel that has refused a request.

A device starts a transfer by presenting a channel number, a direction and a requested length. The block clears the channel's status flags and checks the channel. A disabled channel, or a request whose direction does not match the programmed direction, is refused. The refusal raises the memory-error flag and the channel's error-source bit. An accepted request passes the start address and the clipped length to an address-translation engine. When that engine reports completion, the block sets the terminal-count flag and subtracts the granted length from the count. Moving the data is left to other logic.

Top module: `dmac_regbank`

## Requirements
- R1: After a synchronous reset, every channel register and the error-source register read as zero, `req_ready` is 1, and `grant_valid` and `reject_valid` are 0.
- R2: Channel n occupies bytes 0x100+0x20·n to 0x11F+0x20·n. Within that window, address bits [4:3] select the register: 1 is mode, 2 is count and 3 is start address. Bit 2 is ignored. A read returns the selected register in `bus_rdata` one cycle after `bus_rd_en`.
- R3: `bus_size` gives the width of a write: 0 is a byte, 1 is a halfword, 2 is a word and 3 writes nothing. A byte write places `bus_wdata[7:0]` into byte `bus_addr[1:0]` of the register. A halfword write places `bus_wdata[15:0]` into the upper half when `bus_addr[1]` is 1 and into the lower half otherwise. The other bytes of the register keep their values.
- R4: Slot 0 of each channel window and every address outside the windows read as zero, except 0x200. Writes to those addresses change nothing. The word at 0x200 reads the error-source register, one bit per channel, and ignores writes.
- R5: A request is refused when mode bit 0 (enable) is 0, or when `req_m2d` differs from mode bit 1 (memory-to-device). On a refusal, `reject_valid` pulses one cycle later with `resp_chan` set to the channel, mode bit 9 is set, error-source bit n is set, no grant is issued and the count is unchanged.
- R6: An accepted request pulses `grant_valid` one cycle later. At the same time `grant_addr` equals the start-address register, `grant_len` equals the smaller of `req_len` and the count register, and `resp_chan` equals the channel.
- R7: Every request that is taken clears mode bits 8, 9 and 10 of its channel before the outcome is recorded.
- R8: From a grant until `xfer_done`, `req_ready` is 0, and any request produces neither a grant nor a refusal.
- R9: `xfer_done` while a grant is outstanding sets mode bit 8 (terminal count), reduces the count by the granted length and returns `req_ready` to 1. A zero-length grant is valid.
- R10: Error-source bits are sticky. They accumulate across channels and clear only on reset.
- R11: Request handling never changes mode bits other than 8, 9 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address within the register space |
| bus_size | input | 2 | Write width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-justified for narrow writes |
| bus_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Device transfer request |
| req_chan | input | 3 | Channel of the request |
| req_m2d | input | 1 | Requested direction: 1 means memory to device |
| req_len | input | 32 | Requested length |
| req_ready | output | 1 | High when a request can be taken |
| grant_valid | output | 1 | One-cycle pulse: request accepted |
| grant_addr | output | 32 | Start address handed to the translation engine |
| grant_len | output | 32 | Clipped length handed to the translation engine |
| reject_valid | output | 1 | One-cycle pulse: request refused |
| resp_chan | output | 3 | Channel of the latest grant or refusal |
| xfer_done | input | 1 | Completion from the translation engine |

## Verification
A wrong merge of a narrow write, or a wrong decode, shows up on the very next read. A channel register then holds a stale byte, or an unmapped word reads back nonzero. A wrong acceptance decision appears one cycle after the request, as the wrong pulse, channel, address or length. A stuck or misdirected status update shows only when the mode, count or error-source words are read back after completion. The sweeps therefore read the whole register space after each programming phase, and they read every channel's state after each request.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } bus_size_e;

  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_MODE  = 2'd1,
    SLOT_COUNT = 2'd2,
    SLOT_ADDR  = 2'd3
  } slot_e;

  localparam int MODE_EN_BIT  = 0;
  localparam int MODE_M2D_BIT = 1;
  localparam int ST_TC_BIT    = 8;
  localparam int ST_MERR_BIT  = 9;
  localparam int ST_AERR_BIT  = 10;
endpackage

// File: rtl/dmac_bus_decode.sv
module dmac_bus_decode #(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int NUM_CH     = 8,
  parameter int CH_BASE    = 'h100,
  parameter int WIN_BYTES  = 32,
  parameter int ERR_OFF    = 'h200
) (
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [1:0]                  bus_size,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic                        hit_mode,
  output logic                        hit_count,
  output logic                        hit_addr,
  output logic                        hit_err,
  output logic [$clog2(NUM_CH)-1:0]   sel_chan,
  output logic [DATA_W/8-1:0]         lane_be,
  output logic [DATA_W-1:0]           lane_data
);
  import dmac_pkg::*;

  localparam int NB       = DATA_W / 8;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int WIN_SH   = $clog2(WIN_BYTES);
  localparam int SLOT_SH  = 3;
  localparam int WIN_END  = CH_BASE + NUM_CH * WIN_BYTES;
  localparam logic [NB-1:0] HALF_MASK = NB'((1 << (NB / 2)) - 1);

  logic [ADDR_W-1:0] off;
  logic              in_win;
  slot_e             slot;

  assign off    = bus_addr - ADDR_W'(CH_BASE);
  assign in_win = ({1'b0, bus_addr} >= (ADDR_W+1)'(CH_BASE)) &&
                  ({1'b0, bus_addr} <  (ADDR_W+1)'(WIN_END));
  assign slot   = slot_e'(off[SLOT_SH +: 2]);
  assign sel_chan = off[WIN_SH +: CH_W];

  assign hit_mode  = in_win && (slot == SLOT_MODE);
  assign hit_count = in_win && (slot == SLOT_COUNT);
  assign hit_addr  = in_win && (slot == SLOT_ADDR);
  assign hit_err   = (bus_addr[ADDR_W-1:2] == ERR_OFF[ADDR_W-1:2]);

  always_comb begin
    case (bus_size_e'(bus_size))
      SZ_BYTE: begin
        lane_be   = NB'(1) << bus_addr[1:0];
        lane_data = {NB{bus_wdata[7:0]}};
      end
      SZ_HALF: begin
        lane_be   = bus_addr[1] ? (HALF_MASK << (NB / 2)) : HALF_MASK;
        lane_data = {(NB/2){bus_wdata[15:0]}};
      end
      SZ_WORD: begin
        lane_be   = '1;
        lane_data = bus_wdata;
      end
      default: begin
        lane_be   = '0;
        lane_data = bus_wdata;
      end
    endcase
  end
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_mode,
  input  logic                wr_count,
  input  logic                wr_addr,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                hw_start,
  input  logic                hw_reject,
  input  logic                hw_complete,
  input  logic [DATA_W-1:0]   hw_len,
  output logic [DATA_W-1:0]   mode_q,
  output logic [DATA_W-1:0]   count_q,
  output logic [DATA_W-1:0]   addr_q
);
  import dmac_pkg::*;

  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] mode_m, count_m, addr_m;
  logic [DATA_W-1:0] mode_d, count_d;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign mode_m[b*8 +: 8]  = (wr_mode  && wr_be[b]) ? wr_data[b*8 +: 8] : mode_q[b*8 +: 8];
    assign count_m[b*8 +: 8] = (wr_count && wr_be[b]) ? wr_data[b*8 +: 8] : count_q[b*8 +: 8];
    assign addr_m[b*8 +: 8]  = (wr_addr  && wr_be[b]) ? wr_data[b*8 +: 8] : addr_q[b*8 +: 8];
  end

  // Hardware status updates take precedence over a same-cycle bus write.
  always_comb begin
    mode_d = mode_m;
    if (hw_start) begin
      mode_d[ST_TC_BIT]   = 1'b0;
      mode_d[ST_MERR_BIT] = 1'b0;
      mode_d[ST_AERR_BIT] = 1'b0;
    end
    if (hw_reject)   mode_d[ST_MERR_BIT] = 1'b1;
    if (hw_complete) mode_d[ST_TC_BIT]   = 1'b1;
    count_d = hw_complete ? (count_q - hw_len) : count_m;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      count_q <= '0;
      addr_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      count_q <= count_d;
      addr_q  <= addr_m;
    end
  end

  // R9
  count_dec_chk: assert property (@(posedge clk) disable iff (rst)
    hw_complete |=> (count_q == $past(count_q) - $past(hw_len)));

  // R7
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    hw_start |=> (!mode_q[ST_TC_BIT] && !mode_q[ST_AERR_BIT]));

  // R11
  hw_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_mode && (hw_start || hw_reject || hw_complete)) |=>
      (mode_q[7:0] == $past(mode_q[7:0])) && (mode_q[DATA_W-1:11] == $past(mode_q[DATA_W-1:11])));
endmodule

// File: rtl/dmac_req_ctrl.sv
module dmac_req_ctrl #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  input  logic [$clog2(NUM_CH)-1:0]        req_chan,
  input  logic                             req_m2d,
  input  logic [DATA_W-1:0]                req_len,
  input  logic                             xfer_done,
  input  logic [NUM_CH-1:0][DATA_W-1:0]    mode_all,
  input  logic [NUM_CH-1:0][DATA_W-1:0]    count_all,
  input  logic [NUM_CH-1:0][DATA_W-1:0]    addr_all,
  output logic [NUM_CH-1:0]                start_oh,
  output logic [NUM_CH-1:0]                reject_oh,
  output logic [NUM_CH-1:0]                complete_oh,
  output logic [DATA_W-1:0]                done_len,
  output logic                             req_ready,
  output logic                             grant_valid,
  output logic                             reject_valid,
  output logic [DATA_W-1:0]                grant_addr,
  output logic [DATA_W-1:0]                grant_len,
  output logic [$clog2(NUM_CH)-1:0]        resp_chan,
  output logic [NUM_CH-1:0]                err_src
);
  import dmac_pkg::*;

  logic              busy_q;
  logic              take, accept, finish;
  logic [DATA_W-1:0] sel_mode, sel_count, clip_len;
  logic [NUM_CH-1:0] req_oh, resp_oh;

  assign take      = req_valid && !busy_q;
  assign sel_mode  = mode_all[req_chan];
  assign sel_count = count_all[req_chan];
  assign accept    = take && sel_mode[MODE_EN_BIT] && (sel_mode[MODE_M2D_BIT] == req_m2d);
  assign clip_len  = (req_len < sel_count) ? req_len : sel_count;
  assign finish    = xfer_done && busy_q;

  assign req_oh      = NUM_CH'(1) << req_chan;
  assign resp_oh     = NUM_CH'(1) << resp_chan;
  assign start_oh    = take ? req_oh : '0;
  assign reject_oh   = (take && !accept) ? req_oh : '0;
  assign complete_oh = finish ? resp_oh : '0;
  assign done_len    = grant_len;
  assign req_ready   = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      grant_valid  <= 1'b0;
      reject_valid <= 1'b0;
      grant_addr   <= '0;
      grant_len    <= '0;
      resp_chan    <= '0;
      err_src      <= '0;
    end else begin
      grant_valid  <= accept;
      reject_valid <= take && !accept;
      err_src      <= err_src | reject_oh;
      if (take) resp_chan <= req_chan;
      if (accept) begin
        grant_addr <= addr_all[req_chan];
        grant_len  <= clip_len;
        busy_q     <= 1'b1;
      end else if (finish) begin
        busy_q     <= 1'b0;
      end
    end
  end

  // R5
  // R6
  grant_reject_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(grant_valid && reject_valid));

  // R8
  no_decision_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !xfer_done) |=> (!grant_valid && !reject_valid));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(err_src) & ~err_src) == '0));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank #(
  parameter int NUM_CH    = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int CH_BASE   = 'h100,
  parameter int WIN_BYTES = 32,
  parameter int ERR_OFF   = 'h200
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr_en,
  input  logic                       bus_rd_en,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [1:0]                 bus_size,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       req_valid,
  input  logic [$clog2(NUM_CH)-1:0]  req_chan,
  input  logic                       req_m2d,
  input  logic [DATA_W-1:0]          req_len,
  output logic                       req_ready,
  output logic                       grant_valid,
  output logic [DATA_W-1:0]          grant_addr,
  output logic [DATA_W-1:0]          grant_len,
  output logic                       reject_valid,
  output logic [$clog2(NUM_CH)-1:0]  resp_chan,
  input  logic                       xfer_done
);
  import dmac_pkg::*;

  localparam int CH_W = $clog2(NUM_CH);
  localparam int NB   = DATA_W / 8;

  logic                           hit_mode, hit_count, hit_addr, hit_err;
  logic [CH_W-1:0]                sel_chan;
  logic [NB-1:0]                  lane_be;
  logic [DATA_W-1:0]              lane_data;
  logic [NUM_CH-1:0][DATA_W-1:0]  mode_all, count_all, addr_all;
  logic [NUM_CH-1:0]              start_oh, reject_oh, complete_oh, err_src;
  logic [DATA_W-1:0]              done_len, rd_mux;

  dmac_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH),
    .CH_BASE(CH_BASE), .WIN_BYTES(WIN_BYTES), .ERR_OFF(ERR_OFF)
  ) decode_i (
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_wdata(bus_wdata),
    .hit_mode (hit_mode),
    .hit_count(hit_count),
    .hit_addr (hit_addr),
    .hit_err  (hit_err),
    .sel_chan (sel_chan),
    .lane_be  (lane_be),
    .lane_data(lane_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic chan_sel;
    assign chan_sel = bus_wr_en && (sel_chan == CH_W'(c));

    dmac_channel #(.DATA_W(DATA_W)) chan_i (
      .clk        (clk),
      .rst        (rst),
      .wr_mode    (chan_sel && hit_mode),
      .wr_count   (chan_sel && hit_count),
      .wr_addr    (chan_sel && hit_addr),
      .wr_be      (lane_be),
      .wr_data    (lane_data),
      .hw_start   (start_oh[c]),
      .hw_reject  (reject_oh[c]),
      .hw_complete(complete_oh[c]),
      .hw_len     (done_len),
      .mode_q     (mode_all[c]),
      .count_q    (count_all[c]),
      .addr_q     (addr_all[c])
    );
  end

  dmac_req_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_chan    (req_chan),
    .req_m2d     (req_m2d),
    .req_len     (req_len),
    .xfer_done   (xfer_done),
    .mode_all    (mode_all),
    .count_all   (count_all),
    .addr_all    (addr_all),
    .start_oh    (start_oh),
    .reject_oh   (reject_oh),
    .complete_oh (complete_oh),
    .done_len    (done_len),
    .req_ready   (req_ready),
    .grant_valid (grant_valid),
    .reject_valid(reject_valid),
    .grant_addr  (grant_addr),
    .grant_len   (grant_len),
    .resp_chan   (resp_chan),
    .err_src     (err_src)
  );

  always_comb begin
    rd_mux = '0;
    if (hit_mode)       rd_mux = mode_all[sel_chan];
    else if (hit_count) rd_mux = count_all[sel_chan];
    else if (hit_addr)  rd_mux = addr_all[sel_chan];
    else if (hit_err)   rd_mux = DATA_W'(err_src);
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  // R5
  reject_flags_chk: assert property (@(posedge clk) disable iff (rst)
    reject_valid |-> (err_src[resp_chan] && mode_all[resp_chan][ST_MERR_BIT]));

  // R6
  grant_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> !req_ready);
endmodule

// File: tb/dmac_regbank_tb_top.sv
module dmac_regbank_tb_top;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req_valid = 1'b0, req_m2d = 1'b0, xfer_done = 1'b0;
  logic [2:0]  req_chan = '0;
  logic [31:0] req_len = '0;
  logic        req_ready, grant_valid, reject_valid;
  logic [31:0] grant_addr, grant_len;
  logic [2:0]  resp_chan;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  logic [31:0] m_mode [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [31:0] m_adr  [NCH];
  logic [7:0]  m_err;

  always #5 clk = ~clk;

  dmac_regbank dut_i (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_valid(req_valid), .req_chan(req_chan), .req_m2d(req_m2d), .req_len(req_len),
    .req_ready(req_ready), .grant_valid(grant_valid), .grant_addr(grant_addr),
    .grant_len(grant_len), .reject_valid(reject_valid), .resp_chan(resp_chan),
    .xfer_done(xfer_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int a);
    int ch, slot;
    if (a >= 'h100 && a < 'h200) begin
      ch = (a - 'h100) >> 5;
      slot = (a >> 3) & 3;
      case (slot)
        1: return m_mode[ch];
        2: return m_cnt[ch];
        3: return m_adr[ch];
        default: return 32'h0;
      endcase
    end
    if ((a & ~3) == 'h200) return {24'h0, m_err};
    return 32'h0;
  endfunction

  function automatic bit is_mapped(input int a);
    return (a >= 'h100 && a < 'h200 && ((a >> 3) & 3) != 0);
  endfunction

  task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 10'(a); bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = 10'(a);
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic sweep(input string req);
    logic [31:0] d;
    for (int w = 0; w < 256; w++) begin
      rd(w * 4, d);
      chk(req, d, exp_word(w * 4));
    end
  endtask

  task automatic check_chan(input int ch, input string req);
    logic [31:0] d;
    rd('h100 + ch * 32 + 8, d);  chk({req, " mode"}, d, m_mode[ch]);
    rd('h100 + ch * 32 + 16, d); chk({req, " count"}, d, m_cnt[ch]);
    rd('h200, d);                chk({req, " errsrc"}, d, {24'h0, m_err});
  endtask

  task automatic do_req(input int ch, input bit m2d, input logic [31:0] len);
    bit ok;
    logic [31:0] gl;
    m_mode[ch][10:8] = 3'b000; // R7
    ok = m_mode[ch][0] && (m_mode[ch][1] == m2d);
    gl = (len < m_cnt[ch]) ? len : m_cnt[ch];
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'(ch); req_m2d = m2d; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 grant_valid", 32'(grant_valid), 32'(ok));
    chk("R5 reject_valid", 32'(reject_valid), 32'(!ok));
    chk("R5/R6 resp_chan", 32'(resp_chan), 32'(ch));
    if (!ok) begin
      m_mode[ch][9] = 1'b1;
      m_err[ch] = 1'b1;
      check_chan(ch, "R5 R10 reject");
    end else begin
      chk("R6 grant_addr", grant_addr, m_adr[ch]);
      chk("R6 grant_len", grant_len, gl);
      chk("R8 ready low", 32'(req_ready), 32'h0);
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk("R9 ready back", 32'(req_ready), 32'h1);
      m_mode[ch][8] = 1'b1;
      m_cnt[ch] = m_cnt[ch] - gl;
      check_chan(ch, "R9 R11 complete");
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin m_mode[c] = 0; m_cnt[c] = 0; m_adr[c] = 0; end
    m_err = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", 32'(req_ready), 32'h1);
    chk("R1 grant_valid", 32'(grant_valid), 32'h0);
    chk("R1 reject_valid", 32'(reject_valid), 32'h0);
    sweep("R1 reset sweep");

    // R2: program every channel with word writes
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 32'h1000_0000 * (c + 1) + 32'h11 * c;
      m_cnt[c]  = 32'h0002_0000 + 32'h333 * c;
      m_adr[c]  = 32'h8000_0000 | (32'h1000 * c) | 32'h44;
      wr('h100 + c * 32 + 8,  2'd2, m_mode[c]);
      wr('h100 + c * 32 + 16, 2'd2, m_cnt[c]);
      wr('h100 + c * 32 + 28, 2'd2, m_adr[c]); // bit 2 ignored
    end
    sweep("R2 map sweep");

    // R4: writes to unmapped and read-only words
    for (int w = 0; w < 256; w++)
      if (!is_mapped(w * 4)) wr(w * 4, 2'd2, 32'hFFFF_FFFF);
    sweep("R4 unmapped sweep");

    // R3: narrow write merging
    for (int c = 0; c < NCH; c += 3) begin
      for (int l = 0; l < 4; l++) begin
        wr('h100 + c * 32 + 16 + l, 2'd0, 32'hFFFF_FF00 | 32'(8'hA0 + l));
        m_cnt[c][l*8 +: 8] = 8'hA0 + 8'(l);
        rd('h100 + c * 32 + 16, d);
        chk("R3 byte merge", d, m_cnt[c]);
      end
      for (int h = 0; h < 2; h++) begin
        wr('h100 + c * 32 + 24 + h * 2, 2'd1, 32'hFFFF_0000 | 32'(16'h5A00 + h));
        m_adr[c][h*16 +: 16] = 16'h5A00 + 16'(h);
        rd('h100 + c * 32 + 24, d);
        chk("R3 half merge", d, m_adr[c]);
      end
      wr('h100 + c * 32 + 8, 2'd3, 32'h0);
      rd('h100 + c * 32 + 8, d);
      chk("R3 size3 no write", d, m_mode[c]);
    end

    // Reprogram for requests: en when c%3!=0, direction from bit1 of c, stale status bits
    for (int c = 0; c < NCH; c++) begin
      m_mode[c] = 32'h5A00_07F0 | 32'((c % 3) != 0) | (32'((c >> 1) & 1) << 1);
      m_cnt[c]  = 32'd100 + 32'd50 * c;
      m_adr[c]  = 32'h0010_0000 + 32'h1000 * c;
      wr('h100 + c * 32 + 8,  2'd2, m_mode[c]);
      wr('h100 + c * 32 + 16, 2'd2, m_cnt[c]);
      wr('h100 + c * 32 + 24, 2'd2, m_adr[c]);
    end

    for (int c = 0; c < NCH; c++) begin
      bit dir;
      dir = ((c >> 1) & 1) != 0;
      do_req(c, dir, 32'd30);          // shorter than count (or disabled)
      do_req(c, !dir, 32'd5);          // direction mismatch: R5
      do_req(c, dir, 32'd100000);      // clipped to remaining count
      do_req(c, dir, 32'd7);           // count zero: zero-length grant
    end
    sweep("R10 final sweep");

    // R8: request while a grant is outstanding is ignored
    wr('h100 + 1 * 32 + 16, 2'd2, 32'd40); m_cnt[1] = 32'd40;
    m_mode[1][10:8] = 3'b000;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'd1; req_m2d = 1'b0; req_len = 32'd10;
    @(negedge clk);
    req_chan = 3'd0; req_m2d = 1'b1; req_len = 32'd3;   // held while busy
    chk("R8 first grant", 32'(grant_valid), 32'h1);
    @(negedge clk);
    chk("R8 no grant busy", 32'(grant_valid), 32'h0);
    chk("R8 no reject busy", 32'(reject_valid), 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    m_mode[1][8] = 1'b1; m_cnt[1] = 32'd30;
    check_chan(1, "R8 after busy");
    check_chan(0, "R8 ignored chan");

    done_flag = 1;
    finish_sim();
  end
endmodule